// File: doc/BRIEF.md
# Counting Bloom Snoop Filter

This block tracks which cache lines may be held by a cache, so that snoop probes aimed at lines that cannot be there are dropped. It keeps a table of small saturating counters, indexed by a hash of the 48-bit physical line address. The insert port is fed with the address of every store at dispatch, or of every non-stack line filled into the data cache. The remove port is fed with lines that are evicted or invalidated. The query port takes a snoop address and answers in the same cycle. A miss proves the line is absent, so the probe can be skipped. A hit means only that the line may be present.

The hash ignores the six byte-offset bits and splits the rest of the address into three fields. The low field covers bits 14:6, the middle field bits 32:15 and the high field bits 47:33. Each field is folded down to the index width by XOR, and the three results are XORed together. When address bit 10 is set, the low field is first XORed with the constant 0x22. Each of the 512 entries is a 4-bit counter. Counters stop at 15 and never move again once they reach it, so a line can never be wrongly reported absent. The block has no state machine: each counter cell decodes a three-way action (hold, up, down) through a unique case.

Top module: `cbf_snoop_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every counter, so any query in the cycles after reset returns miss until an insert reaches that index.
- R2: The entry index is fold(A) ^ fold(B) ^ fold(C), where A = addr[14:6], B = addr[32:15], C = addr[47:33]. fold XORs bit i of a field into index bit i mod 9. When addr[10] is 1, the value 0x22 is also XORed into the index. Distinct addresses with the same index share one counter.
- R3: A query with `qry_valid` high returns `qry_hit` low exactly when the counter at its index is zero.
- R4: After an insert with no remove in the same cycle, a query of that address in any later cycle returns hit, as long as no remove has reached that index since.
- R5: A remove with no insert to the same index in the same cycle decrements a counter that is non-zero and below 15.
- R6: A counter saturates at 15. Further inserts leave it at 15, and removes no longer decrement it.
- R7: An insert and a remove that map to the same index in the same cycle cancel, and the counter is unchanged.
- R8: A query sees the counter value from before that cycle's insert or remove is applied.
- R9: A remove that reaches a zero counter is ignored, and the counter stays at zero.
- R10: `qry_hit` is low whenever `qry_valid` is low.
- R11: Address bits 5:0 have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert request valid |
| ins_addr | input | 48 | Physical address to insert |
| rem_valid | input | 1 | Remove request valid |
| rem_addr | input | 48 | Physical address to remove |
| qry_valid | input | 1 | Query valid |
| qry_addr | input | 48 | Snoop address to look up |
| qry_hit | output | 1 | Line may be present (combinational, same cycle) |

## Verification
The hardest state to reach from the ports is a saturated counter. After that comes a remove that is still pending when the counter is pinned at 15, and an insert and a remove that meet on one index through two different addresses. Random traffic over a wide address space almost never produces either. The directed phase therefore inserts one address twenty times and then removes it twenty times. It also builds alias pairs by hand: one pair flips two bits of the middle field that fold onto the same index bit, and another pair lands on the same index only through the 0x22 constant. The random phase then draws from a pool of only twelve addresses, so counters collide, saturate and drain back to zero many times.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
    localparam int CBF_ADDR_W = 48;
    localparam int CBF_IDX_W  = 9;
    localparam int CBF_CNT_W  = 4;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } cnt_act_e;
endpackage

// File: rtl/cbf_line_hash.sv
module cbf_line_hash #(
    parameter int ADDR_W  = 48,
    parameter int IDX_W   = 9,
    parameter int A_LO    = 6,
    parameter int B_LO    = 15,
    parameter int C_LO    = 33,
    parameter int SEL_BIT = 10,
    parameter logic [IDX_W-1:0] SALT = 'h22
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int WA = B_LO - A_LO;
    localparam int WB = C_LO - B_LO;
    localparam int WC = ADDR_W - C_LO;

    // XOR bit i of a field into index bit (i mod IDX_W)
    function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            r[i % IDX_W] = r[i % IDX_W] ^ v[i];
        end
        return r;
    endfunction

    logic [ADDR_W-1:0] fld_a, fld_b, fld_c;
    logic [IDX_W-1:0]  salt_term;

    always_comb begin
        fld_a = (addr >> A_LO) & ((ADDR_W'(1) << WA) - ADDR_W'(1));
        fld_b = (addr >> B_LO) & ((ADDR_W'(1) << WB) - ADDR_W'(1));
        fld_c = (addr >> C_LO) & ((ADDR_W'(1) << WC) - ADDR_W'(1));
        salt_term = addr[SEL_BIT] ? SALT : '0;
        idx = fold(fld_a) ^ salt_term ^ fold(fld_b) ^ fold(fld_c);
    end
endmodule

// File: rtl/cbf_counter_cell.sv
module cbf_counter_cell
    import cbf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_act_e act,
    output logic     nonzero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (act)
            ACT_HOLD: cnt_d = cnt_q;
            ACT_UP:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
            ACT_DOWN: if (cnt_q != '0 && cnt_q != CNT_MAX) cnt_d = cnt_q - CNT_W'(1);
            default:  cnt_d = cnt_q;
        endcase
    end

    assign nonzero = |cnt_q;
endmodule

// File: rtl/cbf_counter_bank.sv
module cbf_counter_bank
    import cbf_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_v,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic             rem_v,
    input  logic [IDX_W-1:0] rem_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             qry_nz
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] nz;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic     up, dn;
        cnt_act_e act;

        assign up = ins_v && (ins_idx == IDX_W'(g));
        assign dn = rem_v && (rem_idx == IDX_W'(g));

        always_comb begin
            if (up && !dn)      act = ACT_UP;
            else if (dn && !up) act = ACT_DOWN;
            else                act = ACT_HOLD;
        end

        cbf_counter_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .act     (act),
            .nonzero (nz[g])
        );
    end

    assign qry_nz = nz[qry_idx];
endmodule

// File: rtl/cbf_snoop_filter.sv
module cbf_snoop_filter
    import cbf_pkg::*;
#(
    parameter int ADDR_W = CBF_ADDR_W,
    parameter int IDX_W  = CBF_IDX_W,
    parameter int CNT_W  = CBF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              rem_valid,
    input  logic [ADDR_W-1:0] rem_addr,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_hit
);
    localparam int NPORT = 3;

    logic [ADDR_W-1:0] port_addr [NPORT];
    logic [IDX_W-1:0]  port_idx  [NPORT];
    logic              qry_nz;

    assign port_addr[0] = ins_addr;
    assign port_addr[1] = rem_addr;
    assign port_addr[2] = qry_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_hash
        cbf_line_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
            .addr (port_addr[p]),
            .idx  (port_idx[p])
        );
    end

    cbf_counter_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ins_v   (ins_valid),
        .ins_idx (port_idx[0]),
        .rem_v   (rem_valid),
        .rem_idx (port_idx[1]),
        .qry_idx (port_idx[2]),
        .qry_nz  (qry_nz)
    );

    assign qry_hit = qry_valid && qry_nz;
endmodule

// File: rtl/cbf_snoop_filter_chk.sv
module cbf_snoop_filter_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              rem_valid,
    input logic [ADDR_W-1:0] rem_addr,
    input logic              qry_valid,
    input logic [ADDR_W-1:0] qry_addr,
    input logic              qry_hit
);
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && qry_valid) |-> !qry_hit);

    p_insert_hits_r4: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !rem_valid) |=>
            (!(qry_valid && qry_addr == $past(ins_addr)) || qry_hit));

    p_cancel_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && rem_valid && ins_addr == rem_addr && qry_valid) |=>
            (!(qry_valid && qry_addr == $past(qry_addr)) || qry_hit == $past(qry_hit)));

    p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid && !rem_valid && qry_valid) |=>
            (!(qry_valid && qry_addr == $past(qry_addr)) || qry_hit == $past(qry_hit)));

    p_no_query_no_hit_r10: assert property (@(posedge clk) disable iff (rst)
        !qry_valid |-> !qry_hit);

    // R11: byte offset does not change the answer
    p_offset_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid && !rem_valid && qry_valid) |=>
            (!(qry_valid && qry_addr[ADDR_W-1:6] == $past(qry_addr[ADDR_W-1:6]))
             || qry_hit == $past(qry_hit)));
endmodule

bind cbf_snoop_filter cbf_snoop_filter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_cbf_snoop_filter.sv
`timescale 1ns/1ps
module tb_cbf_snoop_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid, rem_valid, qry_valid;
    logic [47:0] ins_addr, rem_addr, qry_addr;
    logic        qry_hit;

    int n_checks = 0;
    int n_fail   = 0;
    int model [512];
    logic [47:0] pool [12];

    always #2.5 clk = ~clk;

    cbf_snoop_filter dut (.*);

    // Index rule written from R2
    function automatic int bidx(input logic [47:0] a);
        logic [8:0]  fa, fb, fc;
        logic [17:0] b;
        logic [14:0] c;
        fa = a[14:6];
        b  = a[32:15];
        c  = a[47:33];
        fb = b[8:0] ^ b[17:9];
        fc = c[8:0] ^ {3'b000, c[14:9]};
        if (a[10]) fa = fa ^ 9'h022;
        return int'(fa ^ fb ^ fc);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: qry_hit=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ins_valid = 0; rem_valid = 0; qry_valid = 0;
        ins_addr = '0; rem_addr = '0; qry_addr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        foreach (model[i]) model[i] = 0;
    endtask

    // One cycle: drive at negedge, check pre-update value, then apply rules
    task automatic step(input logic iv, input logic [47:0] ia,
                        input logic rv, input logic [47:0] ra,
                        input logic qv, input logic [47:0] qa,
                        input string req);
        int ii, ri;
        @(negedge clk);
        ins_valid = iv; ins_addr = ia;
        rem_valid = rv; rem_addr = ra;
        qry_valid = qv; qry_addr = qa;
        #1;
        if (qv) check(req, qry_hit, model[bidx(qa)] != 0);
        else    check("R10", qry_hit, 1'b0);
        ii = bidx(ia);
        ri = bidx(ra);
        if (iv && !(rv && ri == ii)) begin
            if (model[ii] != 15) model[ii]++;
        end
        if (rv && !(iv && ri == ii)) begin
            if (model[ri] != 0 && model[ri] != 15) model[ri]--;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [47:0] p, q, q2;
        void'($urandom(32'h5eed_c0de));
        p  = 48'h0000_0000_0400;   // bit10 set, A=0x10 -> index 0x32
        q  = 48'h0000_0019_0000;   // B=0x32 -> index 0x32, bit10 clear
        q2 = 48'h0000_0008_0000;   // B=0x10 -> index 0x10
        do_reset();

        // R1: all miss after reset
        step(0, '0, 0, '0, 1, p,  "R1");
        step(0, '0, 0, '0, 1, q,  "R1");
        step(0, '0, 0, '0, 1, 48'h1234_5678_9ac0, "R1");
        // R8: same-cycle insert and query sees old value
        step(1, p, 0, '0, 1, p, "R8");
        step(0, '0, 0, '0, 1, p, "R4");
        // R2: alias via salt, and non-alias
        step(0, '0, 0, '0, 1, q,  "R2");
        step(0, '0, 0, '0, 1, q2, "R2");
        step(0, '0, 0, '0, 1, p ^ 48'h0000_0100_8000, "R2");
        // R11: offset bits
        step(0, '0, 0, '0, 1, p | 48'h2b, "R11");
        // R10: no query, no hit
        step(0, '0, 0, '0, 0, p, "R10");
        // R5: remove empties the counter
        step(0, '0, 1, p, 1, p, "R5");
        step(0, '0, 0, '0, 1, p, "R5");
        // R9: remove of zero ignored
        step(0, '0, 1, p, 0, '0, "R9");
        step(1, p, 0, '0, 1, p, "R9");
        step(0, '0, 1, p, 1, p, "R9");
        step(0, '0, 0, '0, 1, p, "R9");
        // R7: cancel at zero and at one, through aliasing addresses
        step(1, p, 1, p, 0, '0, "R7");
        step(0, '0, 0, '0, 1, p, "R7");
        step(1, p, 0, '0, 0, '0, "R7");
        step(1, p, 1, q, 1, p, "R7");
        step(0, '0, 0, '0, 1, p, "R7");
        step(0, '0, 1, q, 0, '0, "R7");
        step(0, '0, 0, '0, 1, p, "R7");
        // R6: saturation pins the counter
        for (int i = 0; i < 20; i++) step(1, p, 0, '0, 0, '0, "R6");
        for (int i = 0; i < 20; i++) step(0, '0, 1, p, 1, p, "R6");
        step(0, '0, 0, '0, 1, p, "R6");
        // R1: reset clears a saturated counter
        do_reset();
        step(0, '0, 0, '0, 1, p, "R1");

        // Random phase over a small pool: R3 and R4 against the model
        foreach (pool[i]) pool[i] = {$urandom(), $urandom()} & 48'hffff_ffff_ffff;
        for (int n = 0; n < 3000; n++) begin
            logic iv, rv, qv;
            iv = ($urandom % 2) == 0;
            rv = ($urandom % 3) == 0;
            qv = ($urandom % 4) != 0;
            step(iv, pool[$urandom % 12], rv, pool[$urandom % 12],
                 qv, pool[$urandom % 12] ^ 48'($urandom % 64), "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule